// File: doc/BRIEF.md
# UART Interrupt Mask and Status Controller

This block keeps the interrupt state of a serial port. Event pulses from the receive and transmit logic are latched into a sticky status vector. Software clears status bits by writing ones to them. A mask vector decides which latched events may raise the single interrupt line. The mask cannot be written directly. One write strobe sets mask bits wherever the data word holds a one, and a second strobe clears mask bits the same way. A separate live view returns the unlatched level conditions of the channel, whatever the mask holds.

Each writable register has its own write strobe, and all of them share one data word, so software or a wrapper can pulse several strobes in the same cycle. Reads use a select code and a read strobe. The selected value appears, registered, on the read data port one cycle later. The interrupt line is registered from the AND of status and mask.

Top module: `imc_irq_ctrl`

## Requirements
- R1: After reset the mask and the status vectors are all zero, the interrupt output is low and the read data is zero.
- R2: A pulse on the set strobe turns on every mask bit whose data bit is 1. Mask bits whose data bit is 0 keep their value.
- R3: A pulse on the clear strobe turns off every mask bit whose data bit is 1. Data bits of 0 leave the mask unchanged. With no mask strobe the mask holds.
- R4: When the set and clear strobes are pulsed in the same cycle, a mask bit whose data bit is 1 ends up cleared.
- R5: Reading select code 0 (set register) or select code 1 (clear register) returns zero.
- R6: An event pulse on bit k latches status bit k to 1 whatever the mask holds. The bit stays set until it is cleared. The bit positions are: 0 receive level reached, 1 receive empty, 2 receive full, 3 transmit empty, 4 transmit full, 5 overrun, 6 framing error, 7 parity error, 8 receive timeout; bits 9 to 12 are spare event inputs.
- R7: A pulse on the acknowledge strobe clears every status bit whose data bit is 1. Bits written with 0 keep their value. Select code 2 reads the mask and select code 3 reads the status.
- R8: If an event on bit k arrives in the same cycle as an acknowledge with data bit k set, status bit k remains 1.
- R9: Select code 4 returns the live condition inputs as they are in the cycle of the read, whatever the mask holds.
- R10: The interrupt output equals the OR over all bits of status AND mask, delayed by one clock cycle.
- R11: Only the low 13 data bits take part in writes; higher bits are ignored. Read data bits 13 and above are always zero, and the unused select codes 5 to 7 read zero.
- R12: Read data is updated one cycle after a read strobe and holds its value while no read strobe is given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| set_wr_i | input | 1 | Mask set strobe (write ones to enable) |
| clr_wr_i | input | 1 | Mask clear strobe (write ones to disable) |
| ack_wr_i | input | 1 | Status clear strobe (write ones to clear) |
| wdata_i | input | DATA_W (32) | Shared write data |
| rd_en_i | input | 1 | Read strobe |
| rd_sel_i | input | 3 | Read select code |
| rdata_o | output | DATA_W (32) | Registered read data |
| evt_i | input | N (13) | Event pulses, one per status bit |
| live_i | input | N (13) | Live level conditions for the raw view |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The hardest cases to reach from the ports are two collisions. In one, an event and an acknowledge of the same bit land in one cycle. In the other, the set and clear strobes hit one mask bit together. Through a normal software sequence neither happens on purpose. The bench drives both strobes, or the event pulse and the acknowledge, on the same falling edge so the same rising edge captures them. It then reads the affected register back. The one-cycle lag of the interrupt line is checked by sampling it both right after an enabling write and one cycle later.

// File: rtl/imc_pkg.sv
package imc_pkg;

    localparam int SEL_W = 3;

    typedef enum logic [SEL_W-1:0] {
        SEL_SET  = 3'd0,
        SEL_CLR  = 3'd1,
        SEL_MASK = 3'd2,
        SEL_STAT = 3'd3,
        SEL_LIVE = 3'd4
    } rsel_e;

    localparam int BIT_RX_LEVEL = 0;
    localparam int BIT_RX_EMPTY = 1;
    localparam int BIT_RX_FULL  = 2;
    localparam int BIT_TX_EMPTY = 3;
    localparam int BIT_TX_FULL  = 4;
    localparam int BIT_OVERRUN  = 5;
    localparam int BIT_FRAMING  = 6;
    localparam int BIT_PARITY   = 7;
    localparam int BIT_RX_TOUT  = 8;

endpackage

// File: rtl/imc_mask_reg.sv
module imc_mask_reg #(
    parameter int N = 13
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         set_wr_i,
    input  logic         clr_wr_i,
    input  logic [N-1:0] wbits_i,
    output logic [N-1:0] mask_o
);

    typedef struct packed {
        logic [N-1:0] mask;
    } mask_state_t;

    mask_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (set_wr_i) begin
            st_d.mask = st_d.mask | wbits_i;
        end
        // clear is applied last so it wins on a shared bit
        if (clr_wr_i) begin
            st_d.mask = st_d.mask & ~wbits_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mask_o = st_q.mask;

endmodule

// File: rtl/imc_status_reg.sv
module imc_status_reg #(
    parameter int N = 13
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         ack_wr_i,
    input  logic [N-1:0] wbits_i,
    input  logic [N-1:0] evt_i,
    output logic [N-1:0] stat_o
);

    typedef struct packed {
        logic [N-1:0] stat;
    } stat_state_t;

    stat_state_t  st_d, st_q;
    logic [N-1:0] clr_vec;

    assign clr_vec = ack_wr_i ? wbits_i : '0;

    // one sticky cell per bit; a fresh event overrides a clear
    always_comb begin
        st_d = st_q;
        for (int b = 0; b < N; b++) begin
            if (evt_i[b]) begin
                st_d.stat[b] = 1'b1;
            end else if (clr_vec[b]) begin
                st_d.stat[b] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign stat_o = st_q.stat;

endmodule

// File: rtl/imc_read_port.sv
module imc_read_port
    import imc_pkg::*;
#(
    parameter int N      = 13,
    parameter int DATA_W = 32
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              rd_en_i,
    input  logic [SEL_W-1:0]  rd_sel_i,
    input  logic [N-1:0]      mask_i,
    input  logic [N-1:0]      stat_i,
    input  logic [N-1:0]      live_i,
    output logic [DATA_W-1:0] rdata_o
);

    localparam int PAD = DATA_W - N;

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
    } rd_state_t;

    rd_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rd_en_i) begin
            case (rsel_e'(rd_sel_i))
                SEL_MASK: st_d.rdata = {{PAD{1'b0}}, mask_i};
                SEL_STAT: st_d.rdata = {{PAD{1'b0}}, stat_i};
                SEL_LIVE: st_d.rdata = {{PAD{1'b0}}, live_i};
                default:  st_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata_o = st_q.rdata;

endmodule

// File: rtl/imc_irq_ctrl.sv
module imc_irq_ctrl
    import imc_pkg::*;
#(
    parameter int N      = 13,
    parameter int DATA_W = 32
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              set_wr_i,
    input  logic              clr_wr_i,
    input  logic              ack_wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              rd_en_i,
    input  logic [SEL_W-1:0]  rd_sel_i,
    output logic [DATA_W-1:0] rdata_o,
    input  logic [N-1:0]      evt_i,
    input  logic [N-1:0]      live_i,
    output logic              irq_o
);

    typedef struct packed {
        logic irq;
    } top_state_t;

    top_state_t   st_d, st_q;
    logic [N-1:0] wbits;
    logic [N-1:0] mask_q;
    logic [N-1:0] stat_q;

    assign wbits = wdata_i[N-1:0];

    imc_mask_reg #(.N(N)) i_mask (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .set_wr_i (set_wr_i),
        .clr_wr_i (clr_wr_i),
        .wbits_i  (wbits),
        .mask_o   (mask_q)
    );

    imc_status_reg #(.N(N)) i_stat (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .ack_wr_i (ack_wr_i),
        .wbits_i  (wbits),
        .evt_i    (evt_i),
        .stat_o   (stat_q)
    );

    imc_read_port #(.N(N), .DATA_W(DATA_W)) i_rd (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .rd_en_i  (rd_en_i),
        .rd_sel_i (rd_sel_i),
        .mask_i   (mask_q),
        .stat_i   (stat_q),
        .live_i   (live_i),
        .rdata_o  (rdata_o)
    );

    always_comb begin
        st_d     = st_q;
        st_d.irq = |(stat_q & mask_q);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq_o = st_q.irq;

endmodule

module imc_irq_ctrl_chk #(
    parameter int N      = 13,
    parameter int DATA_W = 32
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              set_wr_i,
    input logic              clr_wr_i,
    input logic              ack_wr_i,
    input logic [DATA_W-1:0] wdata_i,
    input logic              rd_en_i,
    input logic [DATA_W-1:0] rdata_o,
    input logic [N-1:0]      evt_i,
    input logic              irq_o,
    input logic [N-1:0]      mask_i,
    input logic [N-1:0]      stat_i
);

    localparam logic [DATA_W-1:0] LOW_MASK = {{(DATA_W-N){1'b0}}, {N{1'b1}}};

    logic [N-1:0] wlow;
    assign wlow = wdata_i[N-1:0];

    p_set_bits_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (set_wr_i && !clr_wr_i) |=> ((mask_i & $past(wlow)) == $past(wlow)));

    p_mask_steady_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!set_wr_i && !clr_wr_i) |=> $stable(mask_i));

    p_clear_wins_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clr_wr_i |=> ((mask_i & $past(wlow)) == '0));

    p_event_latched_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|evt_i) |=> ((stat_i & $past(evt_i)) == $past(evt_i)));

    p_no_spurious_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (evt_i == '0) |=> ((stat_i & ~$past(stat_i)) == '0));

    p_irq_lag_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o == $past(|(stat_i & mask_i)));

    p_upper_zero_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rdata_o & ~LOW_MASK) == '0);

    p_upper_ignored_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((set_wr_i || clr_wr_i) && ((wdata_i & LOW_MASK) == '0)) |=> $stable(mask_i));

    p_rdata_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rd_en_i |=> $stable(rdata_o));

    p_ack_only_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !ack_wr_i |=> ((~stat_i & $past(stat_i)) == '0));

endmodule

bind imc_irq_ctrl imc_irq_ctrl_chk #(.N(N), .DATA_W(DATA_W)) i_chk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_wr_i (set_wr_i),
    .clr_wr_i (clr_wr_i),
    .ack_wr_i (ack_wr_i),
    .wdata_i  (wdata_i),
    .rd_en_i  (rd_en_i),
    .rdata_o  (rdata_o),
    .evt_i    (evt_i),
    .irq_o    (irq_o),
    .mask_i   (mask_q),
    .stat_i   (stat_q)
);

// File: tb/test_imc_irq_ctrl.sv
module test_imc_irq_ctrl;

    localparam int N      = 13;
    localparam int DATA_W = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              set_wr = 1'b0;
    logic              clr_wr = 1'b0;
    logic              ack_wr = 1'b0;
    logic [DATA_W-1:0] wdata = '0;
    logic              rd_en = 1'b0;
    logic [2:0]        rd_sel = '0;
    logic [DATA_W-1:0] rdata;
    logic [N-1:0]      evt = '0;
    logic [N-1:0]      live = '0;
    logic              irq;

    int n_chk  = 0;
    int n_fail = 0;
    logic [DATA_W-1:0] got;

    always #5 clk = ~clk;

    imc_irq_ctrl #(.N(N), .DATA_W(DATA_W)) i_imc_irq_ctrl (
        .clk_i    (clk),
        .rst_ni   (rst_n),
        .set_wr_i (set_wr),
        .clr_wr_i (clr_wr),
        .ack_wr_i (ack_wr),
        .wdata_i  (wdata),
        .rd_en_i  (rd_en),
        .rd_sel_i (rd_sel),
        .rdata_o  (rdata),
        .evt_i    (evt),
        .live_i   (live),
        .irq_o    (irq)
    );

    task automatic check(input string req, input logic [DATA_W-1:0] act,
                         input logic [DATA_W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic s, input logic c, input logic a,
                      input logic [DATA_W-1:0] d);
        @(negedge clk);
        set_wr = s; clr_wr = c; ack_wr = a; wdata = d;
        @(negedge clk);
        set_wr = 1'b0; clr_wr = 1'b0; ack_wr = 1'b0; wdata = '0;
    endtask

    task automatic rd(input logic [2:0] sel, output logic [DATA_W-1:0] d);
        @(negedge clk);
        rd_en = 1'b1; rd_sel = sel;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic pulse(input logic [N-1:0] e);
        @(negedge clk);
        evt = e;
        @(negedge clk);
        evt = '0;
    endtask

    task automatic t_reset();
        check("R1 rdata", rdata, 0);
        check("R1 irq", {31'd0, irq}, 0);
        rd(3'd2, got); check("R1 mask", got, 0);
        rd(3'd3, got); check("R1 status", got, 0);
    endtask

    task automatic t_enable();
        wr(1, 0, 0, 32'h009); rd(3'd2, got); check("R2 set", got, 32'h009);
        wr(1, 0, 0, 32'h100); rd(3'd2, got); check("R2 keep", got, 32'h109);
    endtask

    task automatic t_disable();
        wr(0, 1, 0, 32'h001); rd(3'd2, got); check("R3 clear", got, 32'h108);
        wr(0, 1, 0, 32'h000); rd(3'd2, got); check("R3 zero data", got, 32'h108);
    endtask

    task automatic t_both();
        wr(1, 1, 0, 32'h00C); rd(3'd2, got); check("R4 clear wins", got, 32'h100);
    endtask

    task automatic t_write_only();
        rd(3'd0, got); check("R5 set reg reads 0", got, 0);
        rd(3'd1, got); check("R5 clr reg reads 0", got, 0);
    endtask

    task automatic t_event();
        pulse(13'h020);
        rd(3'd3, got); check("R6 latched", got, 32'h020);
        check("R10 masked irq", {31'd0, irq}, 0);
        wr(1, 0, 0, 32'h020);
        check("R10 lag", {31'd0, irq}, 0);
        @(negedge clk);
        check("R10 raised", {31'd0, irq}, 1);
    endtask

    task automatic t_clear();
        wr(0, 0, 1, 32'h020); rd(3'd3, got); check("R7 cleared", got, 0);
        check("R10 dropped", {31'd0, irq}, 0);
        pulse(13'h041);
        wr(0, 0, 1, 32'h001); rd(3'd3, got); check("R7 partial", got, 32'h040);
    endtask

    task automatic t_collide();
        @(negedge clk);
        evt = 13'h040; ack_wr = 1'b1; wdata = 32'h040;
        @(negedge clk);
        evt = '0; ack_wr = 1'b0; wdata = '0;
        rd(3'd3, got); check("R8 same bit", got, 32'h040);
        @(negedge clk);
        evt = 13'h080; ack_wr = 1'b1; wdata = 32'h040;
        @(negedge clk);
        evt = '0; ack_wr = 1'b0; wdata = '0;
        rd(3'd3, got); check("R8 other bit", got, 32'h080);
    endtask

    task automatic t_live();
        wr(0, 1, 0, 32'h1FFF);
        live = 13'h1A5;
        rd(3'd4, got); check("R9 live", got, 32'h1A5);
        check("R10 no mask", {31'd0, irq}, 0);
        live = 13'h003;
        rd(3'd4, got); check("R9 live change", got, 32'h003);
    endtask

    task automatic t_upper();
        wr(1, 0, 0, 32'hFFFF_E000); rd(3'd2, got); check("R11 ignored", got, 0);
        wr(1, 0, 0, 32'hFFFF_FFFF); rd(3'd2, got); check("R11 low bits", got, 32'h1FFF);
        check("R10 all enabled", {31'd0, irq}, 1);
        rd(3'd7, got); check("R11 unused sel", got, 0);
    endtask

    task automatic t_hold();
        rd(3'd3, got); check("R12 read", got, 32'h080);
        pulse(13'h001);
        @(negedge clk);
        check("R12 hold", rdata, 32'h080);
        rd(3'd3, got); check("R12 update", got, 32'h081);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_enable();
        t_disable();
        t_both();
        t_write_only();
        t_event();
        t_clear();
        t_collide();
        t_live();
        t_upper();
        t_hold();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog (all requirements): actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule